// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Mode

This block is a 16-bit up-counter with three operating modes that software picks through one 8-bit control register. In reload mode the counter restarts from a 16-bit holding register whenever it rolls over. In capture mode it runs freely and copies its count into that same holding register when an external trigger arrives. In baud mode it acts as a rate generator for a serial port: each rollover reloads the counter and produces a one-cycle tick on the transmit output, the receive output, or both.

Counting is paced either by an internal prescaler (divide by 12 in reload and capture modes, divide by 2 in baud mode) or by falling edges on an external count pin. A falling edge on the trigger pin, when enabled, raises an event flag and causes a capture (capture mode) or a reload (reload and baud modes). Both pins pass through two-flop synchronizers before edge detection. An overflow flag and the event flag share a single interrupt line. Software clears both flags by writing zero to them.

Registers sit behind a plain write strobe, an address and a combinational read bus. Address 0 is the control register. Addresses 1 and 2 are the count, low byte first. Addresses 3 and 4 are the capture/reload register, low byte first.

Top module: `crt_timer`

## Requirements
- R1: After reset, every register reads zero, and the interrupt and both tick outputs are low.
- R2: While the run bit (control bit 0) is 0, the count holds its value unless software writes it or a trigger reloads it.
- R3: With the source select (control bit 1) at 0, outside baud mode, a running counter advances once every 12 clocks.
- R4: In reload mode (control bits 2, 4 and 5 all 0), an increment from 0xFFFF loads the capture/reload register into the count and sets the overflow flag (control bit 6).
- R5: In capture mode (control bit 2 is 1, bits 4 and 5 are 0), an increment from 0xFFFF wraps the count to 0x0000 and sets the overflow flag, and it leaves the capture/reload register unchanged.
- R6: With trigger enable (control bit 3) at 1 in capture mode, a falling edge on the trigger pin copies the count into the capture/reload register and sets the event flag (control bit 7), whether or not the counter runs.
- R7: With trigger enable at 1 in reload mode, a falling edge on the trigger pin loads the capture/reload register into the count and sets the event flag.
- R8: With trigger enable at 0, a trigger edge changes neither the count, nor the capture/reload register, nor the event flag.
- R9: The interrupt output is high while either flag is set. A flag stays set until software writes 0 to it, and a hardware set in the same cycle wins over that write.
- R10: When the transmit select (control bit 5) is 1, baud mode applies: the internal source divides by 2, each rollover reloads the count and gives a one-cycle transmit tick, control bit 2 has no effect, and the overflow flag is not set.
- R11: When the receive select (control bit 4) is 1, rollovers give receive ticks only. With control bit 1 at 1, the counter counts falling edges of the count pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| cnt_pin | input | 1 | External count input (falling edges counted) |
| trig_pin | input | 1 | External trigger input (falling edge active) |
| irq | output | 1 | Interrupt request |
| tx_tick | output | 1 | Transmit rate tick, one cycle wide |
| rx_tick | output | 1 | Receive rate tick, one cycle wide |

## Verification
The assertions assume that both pins idle high through reset. The single-pulse property on the ticks also assumes that count-pin edges are at least two clocks apart. The flag and hold properties assume that the control register changes only through its write strobe. The stimulus raises both pins before reset is released. It holds each pin level for four clocks, and it touches the count only through explicit writes while the counter is stopped, or through the trigger cases that are meant to alter it.

// File: rtl/crt_pkg.sv
`timescale 1ns/1ps
// Shared types for the capture/reload timer: control layout, mode decode
// and register addresses. Assumes an 8-bit register data path.
package crt_pkg;

    // Control register, bit 7 down to bit 0
    typedef struct packed {
        logic ext_flag;   // bit 7: trigger event flag
        logic ovf_flag;   // bit 6: overflow flag
        logic tx_sel;     // bit 5: rollover drives transmit tick
        logic rx_sel;     // bit 4: rollover drives receive tick
        logic trig_en;    // bit 3: trigger pin enable
        logic cap_sel;    // bit 2: capture (1) or reload (0)
        logic ext_src;    // bit 1: count pin (1) or prescaler (0)
        logic run;        // bit 0: counting enable
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_RELOAD  = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_BAUD    = 2'd2
    } mode_e;

    localparam int CTRL_W = $bits(ctrl_t);

    // Either tick select forces baud mode; cap_sel matters only otherwise
    function automatic mode_e decode_mode(input ctrl_t c);
        if (c.tx_sel || c.rx_sel) return MODE_BAUD;
        else if (c.cap_sel)       return MODE_CAPTURE;
        else                      return MODE_RELOAD;
    endfunction

endpackage

// File: rtl/crt_pin_sync.sv
`timescale 1ns/1ps
// Synchronizes an asynchronous pin and flags its falling edges.
// Assumes the pin idles high: the chain resets to ones, so a pin held
// low through reset shows one falling edge shortly after reset.
module crt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the pin through the synchronizer and keep the last value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= chain[LAST];
        end
    end

    // One-cycle pulse when the synchronized level goes from 1 to 0
    always_comb fall = prev & ~chain[LAST];

endmodule

// File: rtl/crt_prescaler.sv
`timescale 1ns/1ps
// Free-running prescaler that gives one tick every SLOW_DIV clocks, or
// every FAST_DIV clocks while fast_sel is high. Assumes FAST_DIV <= SLOW_DIV.
module crt_prescaler #(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_sel,
    output logic tick
);
    localparam int PW = $clog2(SLOW_DIV);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] limit;

    // Choose the terminal count for the active division
    always_comb begin
        limit = fast_sel ? PW'(FAST_DIV - 1) : PW'(SLOW_DIV - 1);
        tick  = (pcnt >= limit);
    end

    // Count up and wrap at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n)    pcnt <= '0;
        else if (tick) pcnt <= '0;
        else           pcnt <= pcnt + 1'b1;
    end

endmodule

// File: rtl/crt_counter.sv
`timescale 1ns/1ps
// Counter and capture/reload register. Software byte writes override
// hardware updates. A trigger captures in capture mode and reloads in the
// other modes. Rollover wraps to zero in capture mode and reloads otherwise.
module crt_counter
    import crt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              cnt_en,
    input  logic              trig_evt,
    input  logic [CNT_W/DATA_W-1:0] cnt_wr_mask,
    input  logic [CNT_W/DATA_W-1:0] rld_wr_mask,
    input  logic [DATA_W-1:0] wr_byte,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  rld_q,
    output logic              carry
);
    localparam int NB = CNT_W / DATA_W;

    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] rld_nxt;

    // Rollover happens on an increment from all ones
    always_comb carry = cnt_en && (cnt_q == '1);

    // Next count: increment, rollover action, trigger reload, byte writes
    always_comb begin
        cnt_nxt = cnt_q;
        if (cnt_en) begin
            if (carry) cnt_nxt = (mode == MODE_CAPTURE) ? '0 : rld_q;
            else       cnt_nxt = cnt_q + 1'b1;
        end
        if (trig_evt && mode != MODE_CAPTURE) cnt_nxt = rld_q;
        for (int b = 0; b < NB; b++) begin
            if (cnt_wr_mask[b]) cnt_nxt[b*DATA_W +: DATA_W] = wr_byte;
        end
    end

    // Next holding value: trigger capture, then byte writes
    always_comb begin
        rld_nxt = rld_q;
        if (trig_evt && mode == MODE_CAPTURE) rld_nxt = cnt_q;
        for (int b = 0; b < NB; b++) begin
            if (rld_wr_mask[b]) rld_nxt[b*DATA_W +: DATA_W] = wr_byte;
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            rld_q <= rld_nxt;
        end
    end

endmodule

// File: rtl/crt_timer.sv
`timescale 1ns/1ps
// Capture/reload timer with a baud-tick mode. It holds the control
// register, the flags, the tick outputs and the register read mux.
// Assumes DATA_W equals the control width, CNT_W is a multiple of DATA_W,
// and both pins idle high while in reset.
module crt_timer
    import crt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3,
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 2,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    output logic              irq,
    output logic              tx_tick,
    output logic              rx_tick
);
    localparam int NB       = CNT_W / DATA_W;
    localparam int A_CTRL   = 0;
    localparam int CNT_BASE = 1;
    localparam int RLD_BASE = CNT_BASE + NB;

    ctrl_t            ctrl_q;
    mode_e            mode;
    logic             baud;
    logic             ctrl_wr;
    logic [NB-1:0]    cnt_wr_mask;
    logic [NB-1:0]    rld_wr_mask;
    logic             cnt_fall;
    logic             trig_fall;
    logic             pre_tick;
    logic             cnt_en;
    logic             trig_evt;
    logic             carry;
    logic             ovf_set;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;

    // Write decode for the control register and each byte lane
    always_comb ctrl_wr = reg_wr && (reg_addr == ADDR_W'(A_CTRL));

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign cnt_wr_mask[b] = reg_wr && (reg_addr == ADDR_W'(CNT_BASE + b));
        assign rld_wr_mask[b] = reg_wr && (reg_addr == ADDR_W'(RLD_BASE + b));
    end

    // Mode decode and count/trigger qualification
    always_comb begin
        mode     = decode_mode(ctrl_q);
        baud     = (mode == MODE_BAUD);
        cnt_en   = ctrl_q.run && (ctrl_q.ext_src ? cnt_fall : pre_tick);
        trig_evt = ctrl_q.trig_en && trig_fall;
        ovf_set  = carry && !baud;
    end

    crt_pin_sync #(.STAGES(SYNC_STG)) u_cnt_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cnt_pin),
        .fall  (cnt_fall)
    );

    crt_pin_sync #(.STAGES(SYNC_STG)) u_trig_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (trig_pin),
        .fall  (trig_fall)
    );

    crt_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_sel (baud),
        .tick     (pre_tick)
    );

    crt_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .cnt_en      (cnt_en),
        .trig_evt    (trig_evt),
        .cnt_wr_mask (cnt_wr_mask),
        .rld_wr_mask (rld_wr_mask),
        .wr_byte     (reg_wdata),
        .cnt_q       (cnt_q),
        .rld_q       (rld_q),
        .carry       (carry)
    );

    // Control register; hardware flag sets win over a software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr)  ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (ovf_set)  ctrl_q.ovf_flag <= 1'b1;
            if (trig_evt) ctrl_q.ext_flag <= 1'b1;
        end
    end

    // Registered one-cycle rate ticks for the serial port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_tick <= 1'b0;
            rx_tick <= 1'b0;
        end else begin
            tx_tick <= carry && baud && ctrl_q.tx_sel;
            rx_tick <= carry && baud && ctrl_q.rx_sel;
        end
    end

    // Shared interrupt request
    always_comb irq = ctrl_q.ovf_flag | ctrl_q.ext_flag;

    // Combinational read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL)) reg_rdata = DATA_W'(ctrl_q);
        for (int b = 0; b < NB; b++) begin
            if (reg_addr == ADDR_W'(CNT_BASE + b)) reg_rdata = cnt_q[b*DATA_W +: DATA_W];
            if (reg_addr == ADDR_W'(RLD_BASE + b)) reg_rdata = rld_q[b*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/crt_checker.sv
`timescale 1ns/1ps
// Property checker for crt_timer, attached by bind. Assumes pins idle
// high through reset and count-pin edges at least two clocks apart.
module crt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             trig_en,
    input logic             rx_sel,
    input logic             tx_sel,
    input logic             ovf_flag,
    input logic             ext_flag,
    input logic             baud,
    input logic             trig_evt,
    input logic             ctrl_wr,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt,
    input logic             tx_tick,
    input logic             rx_tick
);
    // R2: a stopped counter with no write or trigger keeps its value
    assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr && !trig_evt) |=> $stable(cnt));

    // R8: without trigger enable the event flag cannot rise
    assert_trig_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_en && !ext_flag && !ctrl_wr) |=> !ext_flag);

    // R9: overflow flag stays set until software writes the control register
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ctrl_wr) |=> ovf_flag);

    // R10: baud mode never raises the overflow flag
    assert_no_ovf_baud_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (baud && !ovf_flag && !ctrl_wr) |=> !ovf_flag);

    // R10: a transmit tick needs the transmit select
    assert_tx_needs_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |-> $past(tx_sel));

    // R10: ticks are single-cycle pulses
    assert_tx_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |=> !tx_tick);

    // R11: a receive tick needs the receive select
    assert_rx_needs_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick |-> $past(rx_sel));

    // R11: receive ticks are single-cycle pulses
    assert_rx_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick |=> !rx_tick);

endmodule

bind crt_timer crt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q.run),
    .trig_en  (ctrl_q.trig_en),
    .rx_sel   (ctrl_q.rx_sel),
    .tx_sel   (ctrl_q.tx_sel),
    .ovf_flag (ctrl_q.ovf_flag),
    .ext_flag (ctrl_q.ext_flag),
    .baud     (baud),
    .trig_evt (trig_evt),
    .ctrl_wr  (ctrl_wr),
    .cnt_wr   (|cnt_wr_mask),
    .cnt      (cnt_q),
    .tx_tick  (tx_tick),
    .rx_tick  (rx_tick)
);

// File: tb/crt_timer_test.sv
`timescale 1ns/1ps
// Scoreboard bench: register checks are made directly; expected rate
// ticks are queued by a driver task and matched by a monitor process.
module crt_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       irq, tx_tick, rx_tick;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tx_seen = 0;
    int rx_seen = 0;
    int last_tick [2] = '{0, 0};
    bit finished = 0;

    typedef struct { int kind; int gap; } exp_t;
    exp_t sbq[$];

    crt_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
        .trig_pin(trig_pin), .irq(irq), .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] base, input logic [15:0] d);
        wr(base, d[7:0]);
        wr(base + 3'd1, d[15:8]);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd16(input logic [2:0] base, output logic [15:0] d);
        logic [7:0] lo, hi;
        rd(base, lo);
        rd(base + 3'd1, hi);
        d = {hi, lo};
    endtask

    task automatic cnt_pulse();
        cnt_pin = 1'b0; repeat (4) @(negedge clk);
        cnt_pin = 1'b1; repeat (4) @(negedge clk);
    endtask

    task automatic trig_pulse();
        trig_pin = 1'b0; repeat (4) @(negedge clk);
        trig_pin = 1'b1; repeat (4) @(negedge clk);
    endtask

    // Driver: queue n expected ticks of one kind; the first gap is unchecked
    task automatic expect_ticks(input int kind, input int n, input int gap);
        for (int i = 0; i < n; i++) sbq.push_back('{kind, (i == 0) ? 0 : gap});
    endtask

    task automatic handle_tick(input int kind);
        exp_t e;
        total++;
        if (sbq.size() == 0) begin
            bad++;
            $display("FAIL R10/R11: unexpected tick kind=%0d got=1 expected=0", kind);
        end else begin
            e = sbq.pop_front();
            if (e.kind != kind) begin
                bad++;
                $display("FAIL R10/R11: tick kind got=%0d expected=%0d", kind, e.kind);
            end else if (e.gap != 0 && (cyc - last_tick[kind]) != e.gap) begin
                bad++;
                $display("FAIL R10/R11: tick gap got=%0d expected=%0d", cyc - last_tick[kind], e.gap);
            end
        end
        last_tick[kind] = cyc;
    endtask

    // Monitor: pop and compare at every tick
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_tick) begin tx_seen++; handle_tick(0); end
            if (rx_tick) begin rx_seen++; handle_tick(1); end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v8;
        logic [15:0] v16;
        int tx0, rx0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(3'd0, v8);  check("R1 ctrl", v8, 8'h00);
        rd16(3'd1, v16); check("R1 count", v16, 16'h0000);
        rd16(3'd3, v16); check("R1 reload", v16, 16'h0000);
        check("R1 irq", irq, 0);
        check("R1 ticks", {tx_tick, rx_tick}, 0);

        // R3: 120 enabled clocks on the internal source give 10 counts
        wr(3'd0, 8'h01);
        repeat (118) @(negedge clk);
        wr(3'd0, 8'h00);
        rd16(3'd1, v16); check("R3 count after 120 clocks", v16, 16'd10);

        // R2: stopped counter holds
        repeat (50) @(negedge clk);
        rd16(3'd1, v16); check("R2 hold while stopped", v16, 16'd10);

        // R4: reload mode rollover with external source
        wr16(3'd3, 16'hFFFE);
        wr16(3'd1, 16'hFFFE);
        wr(3'd0, 8'h03);
        cnt_pulse(); cnt_pulse();
        rd16(3'd1, v16); check("R4 reloaded count", v16, 16'hFFFE);
        rd(3'd0, v8);    check("R4 overflow flag", v8, 8'h43);
        check("R9 irq on overflow", irq, 1);

        // R9: software clear
        wr(3'd0, 8'h00);
        rd(3'd0, v8); check("R9 cleared ctrl", v8, 8'h00);
        check("R9 irq cleared", irq, 0);

        // R5: capture mode rollover wraps to zero
        wr16(3'd3, 16'h1234);
        wr16(3'd1, 16'hFFFF);
        wr(3'd0, 8'h07);
        cnt_pulse();
        rd16(3'd1, v16); check("R5 wrapped count", v16, 16'h0000);
        rd(3'd0, v8);    check("R5 overflow flag", v8, 8'h47);
        rd16(3'd3, v16); check("R5 holding untouched", v16, 16'h1234);
        wr(3'd0, 8'h00);

        // R6: capture on trigger while stopped
        wr16(3'd1, 16'h0042);
        wr(3'd0, 8'h0C);
        trig_pulse();
        rd16(3'd3, v16); check("R6 captured value", v16, 16'h0042);
        rd(3'd0, v8);    check("R6 event flag", v8, 8'h8C);
        check("R9 irq on event", irq, 1);
        rd16(3'd1, v16); check("R6 count unchanged", v16, 16'h0042);
        wr(3'd0, 8'h00);

        // R8: trigger ignored without enable
        wr(3'd0, 8'h04);
        wr16(3'd1, 16'h0077);
        trig_pulse();
        rd16(3'd3, v16); check("R8 holding unchanged", v16, 16'h0042);
        rd16(3'd1, v16); check("R8 count unchanged", v16, 16'h0077);
        rd(3'd0, v8);    check("R8 no event flag", v8, 8'h04);
        check("R8 irq low", irq, 0);

        // R7: reload on trigger
        wr(3'd0, 8'h08);
        wr16(3'd3, 16'hABCD);
        wr16(3'd1, 16'h0100);
        trig_pulse();
        rd16(3'd1, v16); check("R7 reloaded count", v16, 16'hABCD);
        rd(3'd0, v8);    check("R7 event flag", v8, 8'h88);
        wr(3'd0, 8'h00);

        // R10: baud transmit ticks, divide by 2, capture select ignored
        wr16(3'd3, 16'hFFF0);
        wr16(3'd1, 16'hFFF0);
        rx0 = rx_seen;
        expect_ticks(0, 4, 32);
        wr(3'd0, 8'h25);
        while (sbq.size() != 0) @(negedge clk);
        rd(3'd0, v8); check("R10 no overflow flag in baud", v8, 8'h25);
        wr(3'd0, 8'h00);
        check("R10 no receive ticks", rx_seen - rx0, 0);

        // R11: baud receive ticks from the external count pin
        wr16(3'd3, 16'hFFFE);
        wr16(3'd1, 16'hFFFE);
        tx0 = tx_seen;
        expect_ticks(1, 2, 16);
        wr(3'd0, 8'h13);
        cnt_pulse(); cnt_pulse(); cnt_pulse(); cnt_pulse();
        while (sbq.size() != 0) @(negedge clk);
        wr(3'd0, 8'h00);
        repeat (4) @(negedge clk);
        check("R11 no transmit ticks", tx_seen - tx0, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule